// File: doc/BRIEF.md
# Self-Paging Boot ROM Controller

This block sits between an 8-bit CPU bus with a 16-bit address space and an external ROM of up to 64 KB. After reset the ROM occupies the lower 32 KB of the memory map. A write cycle to one fixed I/O port steps a small counter. The counter's least significant bit takes the ROM out of the map and hands the lower 32 KB to a companion RAM board through a page line. The next write to the port brings the ROM back. Boot code uses this to copy itself into RAM and then switch the ROM out.

A static size selector sets how large a window of the ROM the CPU sees: 1, 2, 4, 8, 16 or 32 KB. A static base selector sets where that window starts inside the ROM. Address bits the window does not cover come from the base selector. So a window always starts on a boundary that is a multiple of its own size. Base bits below that boundary have no effect.

The port strobe is sampled in the block clock domain by a two-state detector. `ST_IDLE` waits for a qualified port write and steps the counter on the first clock edge that sees it, then moves to `ST_HELD` (transition *arm*). `ST_HELD` stays put while the strobe persists and returns to `ST_IDLE` once it is released (transition *release*). Bus inputs are assumed synchronous to `clk`.

Top module: `boot_rom_pager`

## Requirements
- R1: `rom_addr[9:0]` always equals `cpu_addr[9:0]`.
- R2: Size code `size_sel` = k (0..5 meaning 1, 2, 4, 8, 16, 32 KB) passes `cpu_addr[10+i]` to `rom_addr[10+i]` for every i < k. Codes 6 and 7 behave as code 5.
- R3: Each `rom_addr[10+i]` not passed through equals `base_sel[i]`, and `rom_addr[15]` always equals `base_sel[5]`. Base bits under a passed-through position have no effect.
- R4: A port write steps the counter once. A port write means `iorq_n`=0, `wr_n`=0 and `cpu_addr[7:0]`=0x38, whatever `cpu_addr[15:8]` holds. The step happens at the first rising clock edge that samples it.
- R5: A port write strobe held over several clock edges steps the counter only once. Another step needs the strobe to be released first.
- R6: An I/O read of port 0x38, an I/O write to any other port, and any memory cycle leave the counter unchanged.
- R7: `rom_ce_n` is 0 exactly when `mreq_n`=0, `cpu_addr[15]`=0 and the counter is even.
- R8: `rom_oe_n` is 0 exactly when `rom_ce_n` is 0 and `rd_n` is 0.
- R9: `page_out` equals the counter's low bit. It is 1 while the ROM is out and the RAM owns the lower 32 KB.
- R10: Reset (`rst_n`=0, asynchronous) clears the counter and returns the detector to `ST_IDLE`. The ROM is mapped in and `page_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, strobe sampling |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cpu_addr | input | 16 | CPU address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| size_sel | input | 3 | Window size code, 0 = 1 KB .. 5 = 32 KB |
| base_sel | input | 6 | Window base, ROM address bits 15:10 |
| rom_addr | output | 16 | ROM address lines |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| page_out | output | 1 | High while the RAM owns the lower 32 KB |

## Verification
The bench builds the block with its default parameters: port 0x38, a 16-bit address with 10 fixed low bits, five selectable bits and a 4-bit counter. With these values every size code, including the two out-of-range codes, and every base pattern can be reached. Sixteen consecutive port writes take the counter through its wrap. Random memory cycles, port writes of varying hold length, near-miss ports and reads of the port are mixed with directed cases: a long-held strobe, a wrap, and a reset while the ROM is out.

// File: rtl/boot_rom_pager_pkg.sv
package boot_rom_pager_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } strobe_st_e;

    // Clamp a size code to the largest legal value.
    function automatic int unsigned clamp_size(input int unsigned code, input int unsigned max_code);
        return (code > max_code) ? max_code : code;
    endfunction

endpackage

// File: rtl/rom_addr_map.sv
module rom_addr_map #(
    parameter int ADDR_W   = 16,
    parameter int LOW_BITS = 10,
    parameter int SEL_BITS = 5,
    localparam int BASE_W  = ADDR_W - LOW_BITS,
    localparam int SIZE_W  = $clog2(SEL_BITS + 1)
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic [BASE_W-1:0] base_sel,
    output logic [ADDR_W-1:0] rom_addr
);
    import boot_rom_pager_pkg::*;

    int unsigned size_eff;

    always_comb begin
        size_eff = clamp_size(int'(size_sel), SEL_BITS);
    end

    assign rom_addr[LOW_BITS-1:0] = cpu_addr[LOW_BITS-1:0];

    for (genvar i = 0; i < SEL_BITS; i++) begin : g_sel
        assign rom_addr[LOW_BITS+i] = (size_eff > i) ? cpu_addr[LOW_BITS+i] : base_sel[i];
    end

    for (genvar j = SEL_BITS; j < BASE_W; j++) begin : g_fixed
        assign rom_addr[LOW_BITS+j] = base_sel[j];
    end

endmodule

// File: rtl/port_strobe_fsm.sv
module port_strobe_fsm #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    output logic [CNT_W-1:0] count
);
    import boot_rom_pager_pkg::*;

    strobe_st_e state_q, state_d;
    logic       step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (strobe)  state_d = ST_HELD;   // arm
            ST_HELD: if (!strobe) state_d = ST_IDLE;   // release
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        step = 1'b0;
        unique case (state_q)
            ST_IDLE: step = strobe;
            ST_HELD: step = 1'b0;
            default: step = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= count + 1'b1;
    end

endmodule

// File: rtl/rom_select.sv
module rom_select (
    input  logic mreq_n,
    input  logic rd_n,
    input  logic addr_top,
    input  logic rom_off,
    output logic rom_ce_n,
    output logic rom_oe_n
);
    logic sel;

    always_comb begin
        sel      = !mreq_n && !addr_top && !rom_off;
        rom_ce_n = !sel;
        rom_oe_n = !(sel && !rd_n);
    end

endmodule

// File: rtl/boot_rom_pager.sv
module boot_rom_pager #(
    parameter int          ADDR_W   = 16,
    parameter int          LOW_BITS = 10,
    parameter int          SEL_BITS = 5,
    parameter int          CNT_W    = 4,
    parameter logic [7:0]  IO_PORT  = 8'h38,
    localparam int         BASE_W   = ADDR_W - LOW_BITS,
    localparam int         SIZE_W   = $clog2(SEL_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic [BASE_W-1:0] base_sel,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              page_out
);
    logic             port_wr;
    logic [CNT_W-1:0] count;

    assign port_wr = !iorq_n && !wr_n && (cpu_addr[7:0] == IO_PORT);

    rom_addr_map #(
        .ADDR_W  (ADDR_W),
        .LOW_BITS(LOW_BITS),
        .SEL_BITS(SEL_BITS)
    ) u_map (
        .cpu_addr(cpu_addr),
        .size_sel(size_sel),
        .base_sel(base_sel),
        .rom_addr(rom_addr)
    );

    port_strobe_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(port_wr),
        .count (count)
    );

    rom_select u_sel (
        .mreq_n  (mreq_n),
        .rd_n    (rd_n),
        .addr_top(cpu_addr[ADDR_W-1]),
        .rom_off (count[0]),
        .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n)
    );

    assign page_out = count[0];

endmodule

// File: rtl/boot_rom_pager_chk.sv
module boot_rom_pager_chk #(
    parameter int         ADDR_W   = 16,
    parameter int         LOW_BITS = 10,
    parameter logic [7:0] IO_PORT  = 8'h38
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              mreq_n,
    input logic              iorq_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic              page_out
);
    logic hit;
    assign hit = !iorq_n && !wr_n && (cpu_addr[7:0] == IO_PORT);

    // R1
    low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[LOW_BITS-1:0] == cpu_addr[LOW_BITS-1:0]);

    // R4
    step_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !$past(hit)) |=> (page_out != $past(page_out)));

    // R5
    held_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && hit && $past(hit)) |=> $stable(page_out));

    // R6
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(page_out));

    // R7
    ce_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce_n == !(!mreq_n && !cpu_addr[ADDR_W-1] && !page_out));

    // R8
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_oe_n == (rom_ce_n || rd_n));

    // R10
    reset_rom_in_chk: assert property (@(posedge clk)
        !rst_n |-> (!page_out && ($isunknown(mreq_n) || mreq_n || cpu_addr[ADDR_W-1] || !rom_ce_n)));

endmodule

bind boot_rom_pager boot_rom_pager_chk #(
    .ADDR_W  (ADDR_W),
    .LOW_BITS(LOW_BITS),
    .IO_PORT (IO_PORT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_addr(cpu_addr),
    .mreq_n  (mreq_n),
    .iorq_n  (iorq_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .rom_addr(rom_addr),
    .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n),
    .page_out(page_out)
);

// File: tb/boot_rom_pager_tb.sv
module boot_rom_pager_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0]  size_sel = '0;
    logic [5:0]  base_sel = '0;
    logic [15:0] rom_addr;
    logic        rom_ce_n, rom_oe_n, page_out;

    int checks = 0;
    int errors = 0;
    logic exp_page = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_rom_pager u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .size_sel(size_sel),
        .base_sel(base_sel), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n), .page_out(page_out)
    );

    function automatic logic [15:0] model_addr(input logic [15:0] a, input logic [2:0] sz,
                                               input logic [5:0] b);
        int k = (sz > 3'd5) ? 5 : int'(sz);
        logic [15:0] r = a;
        for (int i = 0; i < 5; i++) if (i >= k) r[10+i] = b[i];
        r[15] = b[5];
        return r;
    endfunction

    function automatic logic model_ce_n(input logic mq, input logic a15, input logic pg);
        return !(!mq && !a15 && !pg);
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic [15:0] ea = model_addr(cpu_addr, size_sel, base_sel);
        logic ec = model_ce_n(mreq_n, cpu_addr[15], exp_page);
        logic eo = ec || rd_n;
        check(rom_addr[9:0] == cpu_addr[9:0], {"R1 ", tag}, 32'(rom_addr[9:0]), 32'(cpu_addr[9:0]));
        check(rom_addr[14:10] == ea[14:10], {"R2/R3 ", tag}, 32'(rom_addr), 32'(ea));
        check(rom_addr[15] == ea[15], {"R3 ", tag}, 32'(rom_addr[15]), 32'(ea[15]));
        check(rom_ce_n == ec, {"R7 ", tag}, 32'(rom_ce_n), 32'(ec));
        check(rom_oe_n == eo, {"R8 ", tag}, 32'(rom_oe_n), 32'(eo));
        check(page_out == exp_page, {"R9 ", tag}, 32'(page_out), 32'(exp_page));
    endtask

    // Memory cycle: drive at falling edge, observe combinational outputs.
    task automatic mem_cycle(input logic [15:0] a, input logic rd, input logic [2:0] sz,
                             input logic [5:0] b, input string tag);
        @(negedge clk);
        cpu_addr = a; size_sel = sz; base_sel = b;
        mreq_n = 1'b0; rd_n = rd; wr_n = !rd ? 1'b1 : 1'b0;
        #1 check_outputs(tag);
        @(negedge clk);
        mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        #1 check(page_out == exp_page, {"R6 mem ", tag}, 32'(page_out), 32'(exp_page));
    endtask

    // I/O cycle held over 'hold' rising edges.
    task automatic io_cycle(input logic [7:0] port, input logic [7:0] hi, input logic is_wr,
                            input int hold, input string tag);
        @(negedge clk);
        cpu_addr = {hi, port}; iorq_n = 1'b0;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        iorq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        if (is_wr && port == 8'h38) exp_page = !exp_page;
        #1 check(page_out == exp_page, tag, 32'(page_out), 32'(exp_page));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(page_out == 1'b0, "R10 reset page", 32'(page_out), 0);
        rst_n = 1'b1;
        mem_cycle(16'h0123, 1'b0, 3'd3, 6'h00, "after reset ROM in");

        // R2/R3: every size code incl. out-of-range, all-ones base
        for (int s = 0; s < 8; s++) mem_cycle(16'h7FFF, 1'b0, 3'(s), 6'h3F, "size sweep");
        for (int s = 0; s < 8; s++) mem_cycle(16'h0000, 1'b0, 3'(s), 6'h2A, "size sweep base");

        // R4: single write steps; upper byte ignored
        io_cycle(8'h38, 8'hA5, 1'b1, 1, "R4 port write");
        mem_cycle(16'h1000, 1'b0, 3'd5, 6'h00, "ROM out");
        io_cycle(8'h38, 8'h00, 1'b1, 1, "R4 port write back");
        // R5: long held strobe counts once
        io_cycle(8'h38, 8'h12, 1'b1, 7, "R5 held strobe");
        // R6: read of port, near-miss ports
        io_cycle(8'h38, 8'h00, 1'b0, 2, "R6 port read");
        io_cycle(8'h39, 8'h00, 1'b1, 2, "R6 port 0x39");
        io_cycle(8'hB8, 8'h00, 1'b1, 2, "R6 port 0xB8");
        // Wrap: 16 writes return parity
        for (int i = 0; i < 16; i++) io_cycle(8'h38, 8'(i), 1'b1, 1, "R4 wrap");
        mem_cycle(16'h2345, 1'b0, 3'd2, 6'h15, "after wrap");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 2) begin
                mem_cycle(16'($urandom), 1'($urandom), 3'($urandom), 6'($urandom), "random mem");
            end else begin
                logic [7:0] p = ($urandom % 2) ? 8'h38 : 8'($urandom);
                io_cycle(p, 8'($urandom), 1'($urandom % 4 != 0), 1 + int'($urandom % 3),
                         "R4/R6 random io");
            end
        end

        // R10: reset while ROM is out
        if (!exp_page) io_cycle(8'h38, 8'h00, 1'b1, 1, "R4 page out before reset");
        @(negedge clk);
        rst_n = 1'b0;
        exp_page = 1'b0;
        #1 check(page_out == 1'b0, "R10 async reset", 32'(page_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mem_cycle(16'h0400, 1'b0, 3'd1, 6'h04, "R10 ROM in after reset");
        io_cycle(8'h38, 8'h00, 1'b1, 1, "R10 R4 first write after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule